// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This block decides whether a conditional branch or a conditional move takes effect. A 4-bit condition selector is tested against one of two flag sources. In integer mode the source is a 4-bit flag nibble holding carry, overflow, zero and negative. In floating-point mode the source is a 2-bit compare outcome that reports equal, less, greater or unordered. Each mode has its own set of sixteen conditions.

A request is captured on a valid strobe. The registered verdict appears one clock later, together with its own valid flag. A floating-point request is evaluated only when two enables are both set: a processor-state enable bit and one bit of a floating-point unit status word. If either is clear, the block reports a floating-point-disabled fault and does not report the branch as taken. Instruction decode, flag generation and the redirect of the fetch stream belong to the blocks around this one.

Top module: `cond_eval_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `taken` and `fp_fault` are all 0 after that edge.
- R2: `out_valid` at the edge after a rising edge equals `in_valid` at that edge. When no request is captured, `taken` and `fp_fault` keep their previous values.
- R3: In integer mode (`fp_mode`=0) the flag bits are carry in `int_flags[0]`, overflow in bit 1, zero in bit 2 and negative in bit 3. Conditions 0 to 7 pass respectively for: never, z, z|(n^v), n^v, c|z, c, n and v.
- R4: Integer conditions 8 to 15 are the exact inverses of conditions 0 to 7, in the same order: always, !z, greater, greater-or-equal, greater-unsigned, !c, !n and !v.
- R5: In floating-point mode (`fp_mode`=1) the compare outcome `fcc` means equal for 0, less for 1, greater for 2 and unordered for 3. Conditions 0 to 7 pass respectively for: never, {L,G,U}, {L,G}, {U,L}, {L}, {U,G}, {G} and {U}.
- R6: Floating-point conditions 8 to 15 pass respectively for: always, {E}, {U,E}, {G,E}, {U,G,E}, {L,E}, {U,L,E} and {E,L,G}.
- R7: A floating-point request is evaluated only when `fp_state_en`=1 and `fpu_status[2]`=1. Otherwise the result has `fp_fault`=1 and `taken`=0. The other bits of `fpu_status` have no effect.
- R8: In integer mode `fp_state_en` and `fpu_status` are ignored and `fp_fault` is always 0.
- R9: The mode input selects the flag source. In integer mode `fcc` has no effect, and in floating-point mode `int_flags` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; inputs are captured when high |
| fp_mode | input | 1 | 0 selects integer flags, 1 selects the FP compare outcome |
| cond | input | 4 | Condition selector |
| int_flags | input | 4 | Integer flags: c bit 0, v bit 1, z bit 2, n bit 3 |
| fcc | input | 2 | FP compare outcome: 0 eq, 1 lt, 2 gt, 3 unordered |
| fp_state_en | input | 1 | Processor-state FP enable |
| fpu_status | input | 3 | FP unit status word; bit 2 is the unit enable |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| taken | output | 1 | Condition passed |
| fp_fault | output | 1 | FP request refused because FP is disabled |

## Verification
The bench sweeps every integer condition against all sixteen flag nibbles and every FP condition against all four compare outcomes, and compares each result with a reference written directly from the condition lists. A misplaced flag bit, or a swapped pair of FP codes, shows up as a wrong `taken` on particular rows of these sweeps. The unordered outcome receives special attention: it must pass the not-equal condition but fail the ordered condition, and a design that handled it like equal would fail both checks. The enable gate is tested with each enable clear on its own and with the neighbouring status bits set; a design that decoded the wrong status bit, or that reported `taken` alongside a fault, would be caught there. The idle cycle between requests and a mid-stream reset confirm that a design which let `out_valid` stick high, or which failed to clear the fault, is rejected.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    // Field widths
    localparam int COND_W   = 4;
    localparam int IFLAG_W  = 4;
    localparam int FCC_W    = 2;
    localparam int FPSTAT_W = 3;

    // Bit positions that neighbouring logic depends on
    localparam int FPSTAT_EN_BIT = 2;
    localparam int FLAG_C = 0;
    localparam int FLAG_V = 1;
    localparam int FLAG_Z = 2;
    localparam int FLAG_N = 3;

    // Derived sizes
    localparam int SEL_W      = COND_W - 1;   // low bits pick the base test
    localparam int INV_BIT    = COND_W - 1;   // top bit inverts it
    localparam int FCC_VALUES = 1 << FCC_W;

    typedef enum logic {
        MODE_INT = 1'b0,
        MODE_FP  = 1'b1
    } eval_mode_e;

    typedef struct packed {
        logic vld;
        logic taken;
        logic fault;
    } result_s;

    // Returns the set of compare outcomes (bit k = outcome k) that pass
    // base floating-point test sel. Outcome bit 0=E, 1=L, 2=G, 3=U.
    function automatic logic [FCC_VALUES-1:0] fp_pass_set(input logic [SEL_W-1:0] sel);
        logic [FCC_VALUES-1:0] s;
        case (sel)
            3'd0:    s = 4'b0000;  // never
            3'd1:    s = 4'b1110;  // L G U
            3'd2:    s = 4'b0110;  // L G
            3'd3:    s = 4'b1010;  // U L
            3'd4:    s = 4'b0010;  // L
            3'd5:    s = 4'b1100;  // U G
            3'd6:    s = 4'b0100;  // G
            default: s = 4'b1000;  // U
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cond_int_eval.sv
module cond_int_eval
    import cond_eval_pkg::*;
(
    input  logic [COND_W-1:0]  cond,
    input  logic [IFLAG_W-1:0] flags,
    output logic               pass
);

    logic c, v, z, n;
    logic base;

    always_comb begin
        c = flags[FLAG_C];
        v = flags[FLAG_V];
        z = flags[FLAG_Z];
        n = flags[FLAG_N];
        base = 1'b0;
        case (cond[SEL_W-1:0])
            3'd0:    base = 1'b0;
            3'd1:    base = z;
            3'd2:    base = z | (n ^ v);
            3'd3:    base = n ^ v;
            3'd4:    base = c | z;
            3'd5:    base = c;
            3'd6:    base = n;
            default: base = v;
        endcase
        // upper half of the encoding is the inverse of the lower half
        pass = base ^ cond[INV_BIT];
    end

endmodule

// File: rtl/cond_fp_eval.sv
module cond_fp_eval
    import cond_eval_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [FCC_W-1:0]  fcc,
    output logic              pass
);

    logic [FCC_VALUES-1:0] outcome_oh;
    logic [FCC_VALUES-1:0] pass_set;

    // one-hot decode of the compare outcome
    for (genvar k = 0; k < FCC_VALUES; k++) begin : g_oh
        assign outcome_oh[k] = (fcc == FCC_W'(k));
    end

    always_comb begin
        pass_set = fp_pass_set(cond[SEL_W-1:0]);
        pass     = (|(pass_set & outcome_oh)) ^ cond[INV_BIT];
    end

endmodule

// File: rtl/cond_fp_gate.sv
module cond_fp_gate
    import cond_eval_pkg::*;
(
    input  logic                fp_mode,
    input  logic                fp_state_en,
    input  logic [FPSTAT_W-1:0] fpu_status,
    output logic                fault
);

    logic fp_enabled;

    always_comb begin
        fp_enabled = fp_state_en & fpu_status[FPSTAT_EN_BIT];
        fault      = (eval_mode_e'(fp_mode) == MODE_FP) & ~fp_enabled;
    end

endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
    import cond_eval_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                fp_mode,
    input  logic [COND_W-1:0]   cond,
    input  logic [IFLAG_W-1:0]  int_flags,
    input  logic [FCC_W-1:0]    fcc,
    input  logic                fp_state_en,
    input  logic [FPSTAT_W-1:0] fpu_status,
    output logic                out_valid,
    output logic                taken,
    output logic                fp_fault
);

    logic    int_pass;
    logic    fp_pass;
    logic    gate_fault;
    result_s res_d, res_q;

    cond_int_eval i_int_eval (
        .cond  (cond),
        .flags (int_flags),
        .pass  (int_pass)
    );

    cond_fp_eval i_fp_eval (
        .cond (cond),
        .fcc  (fcc),
        .pass (fp_pass)
    );

    cond_fp_gate i_fp_gate (
        .fp_mode     (fp_mode),
        .fp_state_en (fp_state_en),
        .fpu_status  (fpu_status),
        .fault       (gate_fault)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.fault = gate_fault;
            if (gate_fault) begin
                res_d.taken = 1'b0;
            end else if (eval_mode_e'(fp_mode) == MODE_FP) begin
                res_d.taken = fp_pass;
            end else begin
                res_d.taken = int_pass;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign taken     = res_q.taken;
    assign fp_fault  = res_q.fault;

endmodule

// File: rtl/cond_eval_unit_chk.sv
module cond_eval_unit_chk
    import cond_eval_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                fp_mode,
    input logic [COND_W-1:0]   cond,
    input logic                fp_state_en,
    input logic [FPSTAT_W-1:0] fpu_status,
    input logic                out_valid,
    input logic                taken,
    input logic                fp_fault
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !taken && !fp_fault));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(taken) && $stable(fp_fault)));

    // R7
    fault_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && fp_fault) |-> !taken);

    // R7
    fp_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fp_mode && !(fp_state_en && fpu_status[FPSTAT_EN_BIT])) |=> fp_fault);

    // R8
    int_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fp_mode) |=> !fp_fault);

    // R3
    never_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'h0) |=> !taken);

    // R4
    int_always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fp_mode && cond == 4'h8) |=> taken);

endmodule

bind cond_eval_unit cond_eval_unit_chk i_cond_eval_unit_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .fp_mode     (fp_mode),
    .cond        (cond),
    .fp_state_en (fp_state_en),
    .fpu_status  (fpu_status),
    .out_valid   (out_valid),
    .taken       (taken),
    .fp_fault    (fp_fault)
);

// File: tb/test_cond_eval_unit.sv
`timescale 1ns/1ps
module test_cond_eval_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       fp_mode;
    logic [3:0] cond;
    logic [3:0] int_flags;
    logic [1:0] fcc;
    logic       fp_state_en;
    logic [2:0] fpu_status;
    logic       out_valid;
    logic       taken;
    logic       fp_fault;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cond_eval_unit i_cond_eval_unit (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .fp_mode     (fp_mode),
        .cond        (cond),
        .int_flags   (int_flags),
        .fcc         (fcc),
        .fp_state_en (fp_state_en),
        .fpu_status  (fpu_status),
        .out_valid   (out_valid),
        .taken       (taken),
        .fp_fault    (fp_fault)
    );

    // reference: integer conditions, straight from the requirement lists
    function automatic logic ref_int(input logic [3:0] cc, input logic [3:0] f);
        logic c, v, z, n;
        c = f[0]; v = f[1]; z = f[2]; n = f[3];
        case (cc)
            4'h0: return 1'b0;
            4'h1: return z;
            4'h2: return z | (n ^ v);
            4'h3: return n ^ v;
            4'h4: return c | z;
            4'h5: return c;
            4'h6: return n;
            4'h7: return v;
            4'h8: return 1'b1;
            4'h9: return !z;
            4'hA: return !(z | (n ^ v));
            4'hB: return !(n ^ v);
            4'hC: return !(c | z);
            4'hD: return !c;
            4'hE: return !n;
            default: return !v;
        endcase
    endfunction

    // reference: floating-point conditions
    function automatic logic ref_fp(input logic [3:0] cc, input logic [1:0] o);
        logic e, l, g, u;
        e = (o == 2'd0); l = (o == 2'd1); g = (o == 2'd2); u = (o == 2'd3);
        case (cc)
            4'h0: return 1'b0;
            4'h1: return l | g | u;
            4'h2: return l | g;
            4'h3: return u | l;
            4'h4: return l;
            4'h5: return u | g;
            4'h6: return g;
            4'h7: return u;
            4'h8: return 1'b1;
            4'h9: return e;
            4'hA: return u | e;
            4'hB: return g | e;
            4'hC: return u | g | e;
            4'hD: return l | e;
            4'hE: return u | l | e;
            default: return e | l | g;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // drive one request after a falling edge, sample at the next falling edge
    task automatic apply(input logic m, input logic [3:0] cc, input logic [3:0] f,
                         input logic [1:0] o, input logic en, input logic [2:0] st);
        in_valid    = 1'b1;
        fp_mode     = m;
        cond        = cc;
        int_flags   = f;
        fcc         = o;
        fp_state_en = en;
        fpu_status  = st;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; fp_mode = 1'b0; cond = 4'h0;
        int_flags = 4'h0; fcc = 2'd0; fp_state_en = 1'b0; fpu_status = 3'd0;
        repeat (3) @(negedge clk);
        check("R1", "out_valid after reset", out_valid, 1'b0);
        check("R1", "taken after reset", taken, 1'b0);
        check("R1", "fp_fault after reset", fp_fault, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_int_sweep();
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                apply(1'b0, 4'(cc), 4'(f), 2'(f), 1'b1, 3'b100);
                check(cc < 8 ? "R3" : "R4", $sformatf("int cond=%0h flags=%0h", cc, f),
                      taken, ref_int(4'(cc), 4'(f)));
                check("R2", "out_valid during int sweep", out_valid, 1'b1);
            end
        end
    endtask

    task automatic t_fp_sweep();
        for (int cc = 0; cc < 16; cc++) begin
            for (int o = 0; o < 4; o++) begin
                apply(1'b1, 4'(cc), 4'hF, 2'(o), 1'b1, 3'b100);
                check(cc < 8 ? "R5" : "R6", $sformatf("fp cond=%0h fcc=%0d", cc, o),
                      taken, ref_fp(4'(cc), 2'(o)));
                check("R7", "no fault when enabled", fp_fault, 1'b0);
            end
        end
        // unordered corner: passes not-equal, fails ordered
        apply(1'b1, 4'h1, 4'h0, 2'd3, 1'b1, 3'b111);
        check("R5", "unordered passes not-equal", taken, 1'b1);
        apply(1'b1, 4'hF, 4'h0, 2'd3, 1'b1, 3'b111);
        check("R6", "unordered fails ordered", taken, 1'b0);
    endtask

    task automatic t_fp_gate();
        apply(1'b1, 4'h8, 4'h0, 2'd0, 1'b0, 3'b100);
        check("R7", "state enable clear: fault", fp_fault, 1'b1);
        check("R7", "state enable clear: taken", taken, 1'b0);
        apply(1'b1, 4'h8, 4'h0, 2'd0, 1'b1, 3'b011);
        check("R7", "status bit2 clear: fault", fp_fault, 1'b1);
        check("R7", "status bit2 clear: taken", taken, 1'b0);
        check("R7", "status bit2 clear: valid", out_valid, 1'b1);
        apply(1'b1, 4'h8, 4'h0, 2'd0, 1'b1, 3'b100);
        check("R7", "both enables: fault", fp_fault, 1'b0);
        check("R7", "both enables: taken", taken, 1'b1);
    endtask

    task automatic t_int_ignores_enable();
        apply(1'b0, 4'h8, 4'h0, 2'd0, 1'b0, 3'b000);
        check("R8", "int always with FP disabled: fault", fp_fault, 1'b0);
        check("R8", "int always with FP disabled: taken", taken, 1'b1);
        apply(1'b0, 4'h1, 4'h4, 2'd1, 1'b0, 3'b011);
        check("R8", "int equal with FP disabled", taken, 1'b1);
        check("R8", "int equal with FP disabled: fault", fp_fault, 1'b0);
    endtask

    task automatic t_mode_select();
        // integer mode: fcc changes have no effect (cond=1, z set)
        for (int o = 0; o < 4; o++) begin
            apply(1'b0, 4'h1, 4'h4, 2'(o), 1'b1, 3'b100);
            check("R9", $sformatf("int result with fcc=%0d", o), taken, 1'b1);
        end
        // FP mode: flag changes have no effect (cond=9 equal, fcc=lt)
        for (int f = 0; f < 16; f++) begin
            apply(1'b1, 4'h9, 4'(f), 2'd1, 1'b1, 3'b100);
            check("R9", $sformatf("fp result with flags=%0h", f), taken, 1'b0);
        end
    endtask

    task automatic t_idle_and_reset();
        apply(1'b1, 4'h8, 4'h0, 2'd0, 1'b0, 3'b000);   // faulting result
        in_valid = 1'b0;
        cond = 4'h0; fp_mode = 1'b0;
        @(negedge clk);
        check("R2", "out_valid low with no strobe", out_valid, 1'b0);
        check("R2", "fault held with no strobe", fp_fault, 1'b1);
        check("R2", "taken held with no strobe", taken, 1'b0);
        apply(1'b0, 4'h8, 4'h0, 2'd0, 1'b1, 3'b100);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", "taken held after idle", taken, 1'b1);
        apply(1'b1, 4'h0, 4'h0, 2'd0, 1'b0, 3'b000);   // fault again
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", "mid-run reset: fault", fp_fault, 1'b0);
        check("R1", "mid-run reset: valid", out_valid, 1'b0);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_int_sweep();
        t_fp_sweep();
        t_fp_gate();
        t_int_ignores_enable();
        t_mode_select();
        t_idle_and_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule